// File: doc/BRIEF.md
# Gearing Update Pulse Generator

This block produces the update strobes that a serializer or deserializer uses to move a word between its fast bit clock and its slow word clock. A one-hot shift ring runs on one of two fast clocks, chosen by `clk_pick`. It yields a strobe that is high for one fast cycle in every two or every four fast cycles, depending on the gearing code. A second copy of the strobe is captured on the falling edge of the same fast clock, half a cycle later. `update` exports either the rising-edge copy or the falling-edge copy, as chosen by `phase_pick`.

The ring is preset by a reset taken from either an edge-wide source or a local source. Each source has its own polarity inversion bit. Reset is asserted asynchronously. Release passes through a two-stage synchronizer on the selected fast clock. The gearing code, the clock choice and the reset choice are meant to change only while reset is held. A new setting takes effect from the following release. In single-rate mode the ring is frozen and every strobe stays low.

Top module: `gear_update_gen`

## Requirements
- R1: With gearing code 01 (x2), `upd_pos` is high for exactly one fast cycle in every 2. With code 10 (x4), it is high for exactly one fast cycle in every 4.
- R2: After the selected reset is released, the first `upd_pos` pulse is visible after the (N+2)-th rising edge of the selected fast clock, where N is the ratio (2 or 4). The two extra edges come from the release synchronizer.
- R3: With gearing code 00 (x1) or the unused code 11, `upd_pos`, `upd_neg` and `update` stay low.
- R4: `clk_pick` = 0 runs the ring on `hs_in_clk`. `clk_pick` = 1 runs it on `hs_out_clk`.
- R5: `rst_pick` = 0 takes reset from `edge_rst_n`, and `rst_pick` = 1 takes it from `local_rst_n`. The unselected source has no effect on the outputs.
- R6: With its inversion bit at 0, a reset source is active low. With the bit at 1, the same source is active high.
- R7: While the selected reset is active, `upd_pos` and `upd_neg` are low. Asserting the reset clears them without waiting for a clock edge.
- R8: `upd_neg` takes the value of `upd_pos` on each falling edge of the selected fast clock, so it lags `upd_pos` by half a fast cycle.
- R9: `update` equals `upd_pos` when `phase_pick` = 0 and equals `upd_neg` when `phase_pick` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hs_in_clk | input | 1 | Fast input-side clock |
| hs_out_clk | input | 1 | Fast output-side clock |
| clk_pick | input | 1 | Ring clock choice: 0 = hs_in_clk, 1 = hs_out_clk |
| edge_rst_n | input | 1 | Edge-wide reset source |
| local_rst_n | input | 1 | Local reset source |
| edge_rst_inv | input | 1 | Inverts the polarity of edge_rst_n |
| local_rst_inv | input | 1 | Inverts the polarity of local_rst_n |
| rst_pick | input | 1 | Reset source choice: 0 = edge, 1 = local |
| gear | input | 2 | Gearing code: 00 x1, 01 x2, 10 x4, 11 x1 |
| phase_pick | input | 1 | Exported strobe: 0 = rising-edge copy, 1 = falling-edge copy |
| upd_pos | output | 1 | Strobe registered on the rising fast edge |
| upd_neg | output | 1 | Strobe registered on the falling fast edge |
| update | output | 1 | Selected strobe |

## Verification
Reset is released one nanosecond after a rising edge of the selected clock, and the edges are counted from that point. The first `upd_pos` high is expected after edge N+2, and after that every N edges. `upd_pos` and `update` are sampled one nanosecond after each rising edge. At that moment `update` in falling-phase mode must still show the previous cycle's strobe. `upd_neg` is sampled one nanosecond after the next falling edge, where it must match the strobe of the current cycle. The asynchronous clear is checked one nanosecond after reset is asserted, in a cycle where `upd_pos` is known to be high, with no clock edge in between.

// File: rtl/gear_upd_pkg.sv
// Package gear_upd_pkg
// Shared gearing codes and ring-length decode for the update pulse generator.
// Assumes the longest ring is four bits; the x2 ring uses the lower half.
package gear_upd_pkg;

    localparam int RING_W = 4;
    localparam int LEN_W  = $clog2(RING_W + 1);

    typedef enum logic [1:0] {
        GEAR_X1  = 2'b00,
        GEAR_X2  = 2'b01,
        GEAR_X4  = 2'b10,
        GEAR_OFF = 2'b11
    } gear_e;

    // Active ring length for a gearing code; zero means the ring is idle.
    function automatic logic [LEN_W-1:0] ring_len(input logic [1:0] code);
        case (code)
            GEAR_X2: ring_len = LEN_W'(RING_W / 2);
            GEAR_X4: ring_len = LEN_W'(RING_W);
            default: ring_len = '0;
        endcase
    endfunction

endpackage

// File: rtl/upd_rst_ctrl.sv
// Module upd_rst_ctrl
// Picks the edge-wide or the local reset source and applies that source's
// polarity inversion. Assertion is passed through asynchronously. Release is
// synchronized to the selected fast clock. Assumes the source choice is stable
// while reset is being released.
module upd_rst_ctrl #(
    parameter int SYNC_STAGES = 2
) (
    input  logic fclk,
    input  logic edge_rst_n,
    input  logic local_rst_n,
    input  logic edge_inv,
    input  logic local_inv,
    input  logic src_pick,
    output logic rst_sync_n
);

    logic edge_lvl_n;
    logic local_lvl_n;
    logic raw_n;
    logic [SYNC_STAGES-1:0] sync_q;

    // Source polarity: the inversion bit makes a source active high.
    always_comb begin
        edge_lvl_n  = edge_rst_n ^ edge_inv;
        local_lvl_n = local_rst_n ^ local_inv;
        raw_n       = src_pick ? local_lvl_n : edge_lvl_n;
    end

    // Release synchronizer: clears at once, fills with ones on fclk.
    always_ff @(posedge fclk or negedge raw_n) begin
        if (!raw_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], 1'b1};
        end
    end

    assign rst_sync_n = sync_q[SYNC_STAGES-1];

endmodule

// File: rtl/upd_ring.sv
// Module upd_ring
// One-hot rotating ring preset to a single one in bit 0. The active length
// is 2 or RING_W, taken from the gearing code. The last active bit is
// registered as the rising-edge strobe. Assumes the gearing code changes
// only while rst_n is low. A zero length freezes the ring and keeps the
// strobe low.
module upd_ring
    import gear_upd_pkg::*;
#(
    parameter int W = RING_W
) (
    input  logic       fclk,
    input  logic       rst_n,
    input  logic [1:0] gear,
    output logic       upd_pos
);

    localparam logic [W-1:0] PRESET = W'(1);

    logic [W-1:0]     ring_q;
    logic [W-1:0]     ring_nxt;
    logic [LEN_W-1:0] len;
    logic             active;
    logic             tail;

    // Length decode and tail tap of the active part of the ring.
    always_comb begin
        len    = ring_len(gear);
        active = (len != '0);
        tail   = 1'b0;
        for (int i = 0; i < W; i++) begin
            if (i == int'(len) - 1) begin
                tail = ring_q[i];
            end
        end
    end

    // Rotate the active part by one place; the unused upper bits stay zero.
    always_comb begin
        ring_nxt    = '0;
        ring_nxt[0] = tail;
        for (int i = 1; i < W; i++) begin
            if (i < int'(len)) begin
                ring_nxt[i] = ring_q[i-1];
            end
        end
    end

    // Ring state: preset during reset, rotate while a ratio is active.
    always_ff @(posedge fclk or negedge rst_n) begin
        if (!rst_n) begin
            ring_q <= PRESET;
        end else if (active) begin
            ring_q <= ring_nxt;
        end
    end

    // Rising-edge strobe register fed by the ring tail.
    always_ff @(posedge fclk or negedge rst_n) begin
        if (!rst_n) begin
            upd_pos <= 1'b0;
        end else begin
            upd_pos <= active & tail;
        end
    end

endmodule

// File: rtl/upd_neg_stage.sv
// Module upd_neg_stage
// Re-captures the rising-edge strobe on the falling edge of the same fast
// clock, giving a copy that is half a cycle later. It is cleared with the ring.
module upd_neg_stage (
    input  logic fclk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    // Falling-edge capture with asynchronous clear.
    always_ff @(negedge fclk or negedge rst_n) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/gear_update_gen.sv
// Module gear_update_gen
// Gearing update pulse generator. It chooses the fast clock and the reset
// source, runs the one-hot ring, creates the rising-edge and falling-edge
// strobes and exports one of them. Assumes clk_pick, rst_pick and gear
// change only while the selected reset is active.
module gear_update_gen
    import gear_upd_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int RING_BITS   = RING_W
) (
    input  logic       hs_in_clk,
    input  logic       hs_out_clk,
    input  logic       clk_pick,
    input  logic       edge_rst_n,
    input  logic       local_rst_n,
    input  logic       edge_rst_inv,
    input  logic       local_rst_inv,
    input  logic       rst_pick,
    input  logic [1:0] gear,
    input  logic       phase_pick,
    output logic       upd_pos,
    output logic       upd_neg,
    output logic       update
);

    logic fclk;
    logic rst_sync_n;

    // Fast clock choice; it is switched only under reset.
    assign fclk = clk_pick ? hs_out_clk : hs_in_clk;

    upd_rst_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_rst (
        .fclk        (fclk),
        .edge_rst_n  (edge_rst_n),
        .local_rst_n (local_rst_n),
        .edge_inv    (edge_rst_inv),
        .local_inv   (local_rst_inv),
        .src_pick    (rst_pick),
        .rst_sync_n  (rst_sync_n)
    );

    upd_ring #(.W(RING_BITS)) u_ring (
        .fclk    (fclk),
        .rst_n   (rst_sync_n),
        .gear    (gear),
        .upd_pos (upd_pos)
    );

    upd_neg_stage u_neg (
        .fclk  (fclk),
        .rst_n (rst_sync_n),
        .d     (upd_pos),
        .q     (upd_neg)
    );

    // Exported strobe phase choice.
    assign update = phase_pick ? upd_neg : upd_pos;

endmodule

// File: rtl/gear_update_chk.sv
// Module gear_update_chk
// Property checker bound into gear_update_gen. It watches the strobes
// against the internal fast clock and the synchronized reset.
module gear_update_chk
    import gear_upd_pkg::*;
(
    input logic       fclk,
    input logic       rst_n,
    input logic [1:0] gear,
    input logic       upd_pos,
    input logic       upd_neg
);

    // R1
    x2_period_chk: assert property (@(posedge fclk) disable iff (!rst_n)
        (gear == GEAR_X2 && upd_pos) |=> !upd_pos ##1 upd_pos);

    // R1
    x4_period_chk: assert property (@(posedge fclk) disable iff (!rst_n)
        (gear == GEAR_X4 && upd_pos) |=> !upd_pos ##1 !upd_pos ##1 !upd_pos ##1 upd_pos);

    // R3
    idle_mode_chk: assert property (@(posedge fclk) disable iff (!rst_n)
        (gear == GEAR_X1 || gear == GEAR_OFF) |-> (!upd_pos && !upd_neg));

    // R8
    neg_follow_chk: assert property (@(posedge fclk) disable iff (!rst_n)
        upd_neg == upd_pos);

    // R7
    reset_low_chk: assert property (@(posedge fclk)
        !rst_n |-> (!upd_pos && !upd_neg));

endmodule

bind gear_update_gen gear_update_chk i_gear_update_chk (
    .fclk    (fclk),
    .rst_n   (rst_sync_n),
    .gear    (gear),
    .upd_pos (upd_pos),
    .upd_neg (upd_neg)
);

// File: tb/test_gear_update_gen.sv
module test_gear_update_gen;

    localparam int CLK_P  = 10;
    localparam int OUT_P  = 14;
    localparam int WD_CYC = 200000;

    logic       hs_in_clk = 1'b0;
    logic       hs_out_clk = 1'b0;
    logic       clk_pick = 1'b0;
    logic       edge_rst_n = 1'b0;
    logic       local_rst_n = 1'b0;
    logic       edge_rst_inv = 1'b0;
    logic       local_rst_inv = 1'b0;
    logic       rst_pick = 1'b0;
    logic [1:0] gear = 2'b01;
    logic       phase_pick = 1'b0;
    logic       upd_pos;
    logic       upd_neg;
    logic       update;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_P/2) hs_in_clk = ~hs_in_clk;
    always #(OUT_P/2) hs_out_clk = ~hs_out_clk;

    gear_update_gen i_gear_update_gen (
        .hs_in_clk     (hs_in_clk),
        .hs_out_clk    (hs_out_clk),
        .clk_pick      (clk_pick),
        .edge_rst_n    (edge_rst_n),
        .local_rst_n   (local_rst_n),
        .edge_rst_inv  (edge_rst_inv),
        .local_rst_inv (local_rst_inv),
        .rst_pick      (rst_pick),
        .gear          (gear),
        .phase_pick    (phase_pick),
        .upd_pos       (upd_pos),
        .upd_neg       (upd_neg),
        .update        (update)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    task automatic at_rise();
        if (clk_pick) @(posedge hs_out_clk); else @(posedge hs_in_clk);
        #1;
    endtask

    task automatic at_fall();
        if (clk_pick) @(negedge hs_out_clk); else @(negedge hs_in_clk);
        #1;
    endtask

    // Drive both sources; the selected one to 'on', the other held active (R5).
    task automatic drive_rst(input bit on);
        if (rst_pick) begin
            local_rst_n = on ? local_rst_inv : ~local_rst_inv;
            edge_rst_n  = edge_rst_inv;
        end else begin
            edge_rst_n  = on ? edge_rst_inv : ~edge_rst_inv;
            local_rst_n = local_rst_inv;
        end
    endtask

    // Configure under reset, check the held state, then release after a rising edge.
    task automatic setup(input string scn, input logic [1:0] g, input bit cp, input bit rp,
                         input bit ei, input bit li, input bit ph);
        drive_rst(1'b1);
        #1;
        gear = g; clk_pick = cp; rst_pick = rp;
        edge_rst_inv = ei; local_rst_inv = li; phase_pick = ph;
        drive_rst(1'b1);
        repeat (3) at_rise();
        chk({scn, " R7 held pos"}, upd_pos, 1'b0);
        chk({scn, " R7 held neg"}, upd_neg, 1'b0);
        drive_rst(1'b0);
    endtask

    // Count edges from release; N = 0 means idle mode.
    task automatic run_gear(input string scn, input int n);
        int   first = n + 2;
        int   last  = (n == 0) ? 16 : first + 3 * n;
        logic prev  = 1'b0;
        for (int e = 1; e <= last; e++) begin
            logic exp = (n != 0) && (e >= first) && ((e - first) % n == 0);
            at_rise();
            chk({scn, (e == first) ? " R2 first pulse" : " R1 pos pattern"}, upd_pos, exp);
            chk({scn, " R9 update"}, update, phase_pick ? prev : exp);
            at_fall();
            chk({scn, " R8 neg copy"}, upd_neg, exp);
            prev = exp;
        end
    endtask

    // Assert reset while pos is high; outputs clear with no clock edge.
    task automatic async_clear(input string scn);
        drive_rst(1'b1);
        #1;
        chk({scn, " R7 async pos"}, upd_pos, 1'b0);
        chk({scn, " R7 async neg"}, upd_neg, 1'b0);
    endtask

    task automatic t_reset_state();
        repeat (4) at_rise();
        chk("R7 reset pos", upd_pos, 1'b0);
        chk("R7 reset neg", upd_neg, 1'b0);
        chk("R7 reset update", update, 1'b0);
    endtask

    task automatic t_x2_in_edge();
        setup("R4 x2 in-clk edge-src", 2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        run_gear("R4 x2 in-clk edge-src", 2);
        async_clear("x2");
    endtask

    task automatic t_x4_out_local();
        setup("R5 x4 out-clk local-src", 2'b10, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
        run_gear("R5 x4 out-clk local-src", 4);
        async_clear("x4");
    endtask

    task automatic t_idle();
        setup("R3 x1", 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        run_gear("R3 x1", 0);
        setup("R3 code11", 2'b11, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
        run_gear("R3 code11", 0);
    endtask

    task automatic t_invert();
        setup("R6 edge-inv x2", 2'b01, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
        run_gear("R6 edge-inv x2", 2);
        async_clear("R6 edge-inv");
        setup("R6 local-inv x4", 2'b10, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
        run_gear("R6 local-inv x4", 4);
        async_clear("R6 local-inv");
    endtask

    initial begin
        #(CLK_P * WD_CYC);
        n_bad++;
        $display("FAIL watchdog expired at %0t", $time);
        report();
    end

    initial begin
        t_reset_state();
        t_x2_in_edge();
        t_x4_out_local();
        t_idle();
        t_invert();
        report();
    end

endmodule